// File: doc/BRIEF.md
# Interrupt entry sequencer

This block sits next to a simple 32-bit processor core and carries out interrupt entry and interrupt return. The core reports each instruction boundary with `insn_done`. The block looks at the request lines only on that strobe. A maskable request is taken only while the enable bit of the core's flags word is set. A non-maskable request is always taken and uses a fixed vector. For a maskable request the 8-bit vector is received from an external interrupt controller over a valid/ready handshake. The controller may raise `vec_valid` at any time and must hold `vec_data` steady while it is high. The block raises `vec_ready` only while it waits for a vector, and the vector transfers on the cycle where both are high.

The block fetches the handler's 8-byte gate from a descriptor table at `idt_base + vector*8` as two 32-bit reads. If the gate is not present, it raises a fault and stops. If the gate is present, it pushes three words onto the core's stack: flags, then the code selector zero-extended to 32 bits, then the program counter. It then hands the core a new selector, a new program counter, the flags with the enable bit cleared, and the new stack pointer. A return request pops the program counter, the selector and the flags in that order and hands them back. Memory is a single word port: a request is held until it is acknowledged.

Top module: `ient_seq`

## Requirements
- R1: Requests are looked at only in a cycle where `insn_done` is 1 and the block is idle. While `insn_done` is 0, no request starts any activity.
- R2: The enable flag is bit 9 of `cur_flags`. When that bit is 0, a maskable request is ignored. When it is 1, the request is taken. A non-maskable request is taken regardless of the bit, uses vector 2, and never raises `vec_ready`.
- R3: When several requests arrive on the same boundary, the non-maskable request wins over a maskable one, and a taken maskable request wins over a return request.
- R4: After a maskable request is taken, `vec_ready` stays high and no memory request is made until `vec_valid` is 1. The vector is `vec_data` at that handshake.
- R5: The gate is read as two words: first at `idt_base + vector*8`, then at that address + 4. In the first word, bits 15:0 are offset[15:0] and bits 31:16 are the selector. In the second word, bits 31:16 are offset[31:16] and bit 15 is the present bit.
- R6: On entry, three word writes follow the gate reads. Flags are written at sp-4, the zero-extended selector at sp-8, and the program counter at sp-12, where sp is `cur_sp` at the boundary.
- R7: After the pushes, `upd_valid` pulses for one cycle. At that pulse, `upd_pc` is the joined offset, `upd_cs` is the gate selector, `upd_flags` is the saved flags with bit 9 cleared, and `upd_sp` is sp-12.
- R8: If the present bit is 0, `fault` pulses for one cycle. No write is made and `upd_valid` is not raised.
- R9: A return reads the program counter at sp, the selector (low 16 bits) at sp+4 and the flags at sp+8. `upd_valid` then pulses with those values and `upd_sp` equal to sp+12.
- R10: `busy` is 0 out of reset. It is 1 from the cycle after a request is taken through the cycle of `upd_valid` or `fault`, and 0 in the cycle after.
- R11: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| iret_req | input | 1 | Return-from-interrupt request |
| vec_valid | input | 1 | Controller offers a vector |
| vec_ready | output | 1 | Sequencer waits for a vector |
| vec_data | input | 8 | Interrupt vector |
| idt_base | input | 32 | Byte address of the gate table |
| cur_flags | input | 32 | Core flags at the boundary |
| cur_cs | input | 16 | Core code selector at the boundary |
| cur_pc | input | 32 | Core program counter at the boundary |
| cur_sp | input | 32 | Core stack pointer at the boundary |
| upd_valid | output | 1 | One-cycle strobe: load the update values |
| upd_flags | output | 32 | New flags |
| upd_cs | output | 16 | New code selector |
| upd_pc | output | 32 | New program counter |
| upd_sp | output | 32 | New stack pointer |
| busy | output | 1 | Entry or return in progress |
| fault | output | 1 | One-cycle strobe: gate not present |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume the following about the inputs. `mem_ack` is a one-cycle pulse given only while `mem_req` is high. `vec_data` does not change while `vec_valid` is high. `insn_done` is 0 during reset. The core keeps the `cur_*` inputs steady on the boundary cycle. The bench memory keeps to these rules. It answers only a pending request, after a latency of zero to two cycles, and drops `mem_ack` for one cycle between transfers. The bench changes the vector and the request lines only on falling edges, while the block is idle or waiting for a vector.

// File: rtl/ient_pkg.sv
package ient_pkg;
  localparam int WORD_W   = 32;
  localparam int SEL_W    = 16;
  localparam int P_BIT    = 15;
  localparam int WORD_B   = WORD_W / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_VEC, S_GLO, S_GHI, S_CHK, S_PF, S_PCS, S_PPC,
    S_JMP, S_FLT, S_RPC, S_RCS, S_RFL, S_RET
  } st_e;

  typedef struct packed {
    logic [WORD_W-1:0] off;
    logic [SEL_W-1:0]  sel;
    logic              present;
  } gate_t;
endpackage

// File: rtl/ient_arbiter.sv
module ient_arbiter (
  input  logic idle,
  input  logic insn_done,
  input  logic nmi_req,
  input  logic irq_req,
  input  logic iret_req,
  input  logic ie,
  output logic take_nmi,
  output logic take_irq,
  output logic take_iret
);
  logic at_bnd, irq_ok;
  assign at_bnd    = idle && insn_done;
  assign irq_ok    = irq_req && ie;
  assign take_nmi  = at_bnd && nmi_req;
  assign take_irq  = at_bnd && !nmi_req && irq_ok;
  assign take_iret = at_bnd && !nmi_req && !irq_ok && iret_req;
endmodule

// File: rtl/ient_gate_dec.sv
module ient_gate_dec import ient_pkg::*; (
  input  logic [WORD_W-1:0] w_lo,
  input  logic [15:0]       off_hi,
  input  logic              p_bit,
  output gate_t             gate
);
  always_comb begin
    gate.off     = {off_hi, w_lo[15:0]};
    gate.sel     = w_lo[31:16];
    gate.present = p_bit;
  end
endmodule

// File: rtl/ient_frame_mux.sv
module ient_frame_mux import ient_pkg::*; (
  input  st_e               st,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] gate_a,
  input  logic [WORD_W-1:0] flags,
  input  logic [SEL_W-1:0]  cs,
  input  logic [WORD_W-1:0] pc,
  output logic              req,
  output logic              we,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] wdata
);
  logic [WORD_W-1:0] sp_dn;
  assign sp_dn = sp - WORD_W'(WORD_B);

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (st)
      S_GLO: begin req = 1'b1; addr = gate_a; end
      S_GHI: begin req = 1'b1; addr = gate_a + WORD_W'(WORD_B); end
      S_PF:  begin req = 1'b1; we = 1'b1; addr = sp_dn; wdata = flags; end
      S_PCS: begin req = 1'b1; we = 1'b1; addr = sp_dn; wdata = WORD_W'(cs); end
      S_PPC: begin req = 1'b1; we = 1'b1; addr = sp_dn; wdata = pc; end
      S_RPC, S_RCS, S_RFL: begin req = 1'b1; addr = sp; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ient_seq.sv
module ient_seq import ient_pkg::*; #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2,
  parameter int IE_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_done,
  input  logic              irq_req,
  input  logic              nmi_req,
  input  logic              iret_req,
  input  logic              vec_valid,
  output logic              vec_ready,
  input  logic [VEC_W-1:0]  vec_data,
  input  logic [31:0]       idt_base,
  input  logic [31:0]       cur_flags,
  input  logic [15:0]       cur_cs,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       cur_sp,
  output logic              upd_valid,
  output logic [31:0]       upd_flags,
  output logic [15:0]       upd_cs,
  output logic [31:0]       upd_pc,
  output logic [31:0]       upd_sp,
  output logic              busy,
  output logic              fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int GATE_SH = $clog2(2 * WORD_B);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
  localparam logic [WORD_W-1:0] IE_MASK = WORD_W'(1) << IE_BIT;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_B);

  st_e               st;
  logic [WORD_W-1:0] sp_r, sav_flags, sav_pc, glo;
  logic [SEL_W-1:0]  sav_cs;
  logic [15:0]       ghi_off;
  logic              ghi_p;
  logic [VEC_W-1:0]  vec_r;
  logic [WORD_W-1:0] gate_a;
  gate_t             gate;
  logic              take_nmi, take_irq, take_iret;

  assign gate_a = idt_base + (WORD_W'(vec_r) << GATE_SH);

  ient_arbiter u_arb (
    .idle(st == S_IDLE), .insn_done(insn_done), .nmi_req(nmi_req),
    .irq_req(irq_req), .iret_req(iret_req), .ie(cur_flags[IE_BIT]),
    .take_nmi(take_nmi), .take_irq(take_irq), .take_iret(take_iret)
  );

  ient_gate_dec u_dec (
    .w_lo(glo), .off_hi(ghi_off), .p_bit(ghi_p), .gate(gate)
  );

  ient_frame_mux u_mux (
    .st(st), .sp(sp_r), .gate_a(gate_a), .flags(sav_flags), .cs(sav_cs),
    .pc(sav_pc), .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sp_r      <= '0;
      sav_flags <= '0;
      sav_pc    <= '0;
      sav_cs    <= '0;
      glo       <= '0;
      ghi_off   <= '0;
      ghi_p     <= 1'b0;
      vec_r     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (take_nmi || take_irq) begin
            sav_flags <= cur_flags;
            sav_cs    <= cur_cs;
            sav_pc    <= cur_pc;
            sp_r      <= cur_sp;
            if (take_nmi) begin
              vec_r <= NMI_V;
              st    <= S_GLO;
            end else begin
              st    <= S_VEC;
            end
          end else if (take_iret) begin
            sp_r <= cur_sp;
            st   <= S_RPC;
          end
        end
        S_VEC: if (vec_valid) begin vec_r <= vec_data; st <= S_GLO; end
        S_GLO: if (mem_ack) begin glo <= mem_rdata; st <= S_GHI; end
        S_GHI: if (mem_ack) begin
          ghi_off <= mem_rdata[31:16];
          ghi_p   <= mem_rdata[P_BIT];
          st      <= S_CHK;
        end
        S_CHK: st <= gate.present ? S_PF : S_FLT;
        S_PF:  if (mem_ack) begin sp_r <= sp_r - STEP; st <= S_PCS; end
        S_PCS: if (mem_ack) begin sp_r <= sp_r - STEP; st <= S_PPC; end
        S_PPC: if (mem_ack) begin sp_r <= sp_r - STEP; st <= S_JMP; end
        S_RPC: if (mem_ack) begin sav_pc <= mem_rdata; sp_r <= sp_r + STEP; st <= S_RCS; end
        S_RCS: if (mem_ack) begin sav_cs <= mem_rdata[SEL_W-1:0]; sp_r <= sp_r + STEP; st <= S_RFL; end
        S_RFL: if (mem_ack) begin sav_flags <= mem_rdata; sp_r <= sp_r + STEP; st <= S_RET; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != S_IDLE);
    vec_ready = (st == S_VEC);
    fault     = (st == S_FLT);
    upd_valid = (st == S_JMP) || (st == S_RET);
    upd_flags = '0;
    upd_cs    = '0;
    upd_pc    = '0;
    upd_sp    = '0;
    if (st == S_JMP) begin
      upd_flags = sav_flags & ~IE_MASK;
      upd_cs    = gate.sel;
      upd_pc    = gate.off;
      upd_sp    = sp_r;
    end else if (st == S_RET) begin
      upd_flags = sav_flags;
      upd_cs    = sav_cs;
      upd_pc    = sav_pc;
      upd_sp    = sp_r;
    end
  end

  p_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_done));
  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VEC && $past(st == S_IDLE)) |-> $past(cur_flags[IE_BIT]));
  p_nmi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_IDLE && insn_done && nmi_req) |-> (st == S_GLO && vec_r == NMI_V));
  p_vec_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready |-> !mem_req);
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!busy && !upd_valid && !fault));
  p_upd_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (!busy && !upd_valid));
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/test_ient_seq.sv
module test_ient_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, insn_done, irq_req, nmi_req, iret_req, vec_valid, vec_ready;
  logic [7:0] vec_data;
  logic [31:0] idt_base, cur_flags, cur_pc, cur_sp, upd_flags, upd_pc, upd_sp;
  logic [15:0] cur_cs, upd_cs;
  logic upd_valid, busy, fault, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  ient_seq i_ient_seq (.*);

  localparam logic [31:0] BASE = 32'h0000_8000;
  int checks = 0, fails = 0, lat = 0, cnt = 0;
  bit finished = 0, saw_ready = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] wr_a[$], wr_d[$], rd_a[$];
  logic [31:0] fa, fd;
  logic fw;
  logic got_upd, got_fault;
  logic [31:0] u_pc, u_flags, u_sp;
  logic [15:0] u_cs;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void put_gate(logic [7:0] v, logic [31:0] off, logic [15:0] sel, logic [7:0] attr);
    mem[BASE + {21'd0, v, 3'b000}]     = {sel, off[15:0]};
    mem[BASE + {21'd0, v, 3'b000} + 4] = {off[31:16], attr, 8'h00};
  endfunction

  // memory model and per-clock monitor
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (vec_ready) saw_ready = 1;
      if (mem_req) chk(busy == 1'b1, "R10 busy during memory access", busy, 1);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req && rst_n) begin
        if (cnt == 0) begin fa = mem_addr; fw = mem_we; fd = mem_wdata; end
        if (cnt >= lat) begin
          chk(mem_addr == fa && mem_we == fw && mem_wdata == fd, "R11 request held",
              {mem_addr, mem_wdata}, {fa, fd});
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_a.push_back(mem_addr);
            wr_d.push_back(mem_wdata);
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            rd_a.push_back(mem_addr);
          end
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic start(input bit irq, input bit nmi, input bit iret, input string tag);
    wr_a.delete(); wr_d.delete(); rd_a.delete();
    saw_ready = 0;
    @(negedge clk);
    irq_req = irq; nmi_req = nmi; iret_req = iret; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_req = 1'b0; nmi_req = 1'b0; iret_req = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after accept"}, busy, 1);
  endtask

  task automatic wait_done(input string tag);
    got_upd = 0; got_fault = 0;
    for (int i = 0; i < 200; i++) begin
      if (upd_valid) begin
        got_upd = 1; u_pc = upd_pc; u_cs = upd_cs; u_flags = upd_flags; u_sp = upd_sp;
        break;
      end
      if (fault) begin got_fault = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(busy == 1'b0 && upd_valid == 1'b0 && fault == 1'b0, {tag, " R10 idle after end"},
        {busy, upd_valid, fault}, 0);
  endtask

  task automatic verify_entry(input logic [7:0] v, input logic [31:0] fl, input logic [15:0] cs,
                              input logic [31:0] pc, input logic [31:0] sp,
                              input logic [31:0] off, input logic [15:0] sel, input string tag);
    logic [31:0] ga;
    ga = BASE + {21'd0, v, 3'b000};
    chk(rd_a.size() == 2 && rd_a[0] == ga && rd_a[1] == ga + 4, {tag, " R5 gate reads"},
        rd_a.size() > 0 ? rd_a[0] : 0, ga);
    chk(wr_a.size() == 3, {tag, " R6 push count"}, wr_a.size(), 3);
    if (wr_a.size() == 3) begin
      chk(wr_a[0] == sp - 4 && wr_d[0] == fl, {tag, " R6 flags push"}, {wr_a[0], wr_d[0]}, {sp - 32'd4, fl});
      chk(wr_a[1] == sp - 8 && wr_d[1] == {16'h0, cs}, {tag, " R6 selector push"},
          {wr_a[1], wr_d[1]}, {sp - 32'd8, 16'h0, cs});
      chk(wr_a[2] == sp - 12 && wr_d[2] == pc, {tag, " R6 pc push"}, {wr_a[2], wr_d[2]}, {sp - 32'd12, pc});
    end
    chk(got_upd && !got_fault, {tag, " R7 update strobe"}, {got_upd, got_fault}, 2);
    chk(u_pc == off && u_cs == sel, {tag, " R7 handler pc/cs"}, {u_pc, 16'h0, u_cs}, {off, 16'h0, sel});
    chk(u_flags == (fl & ~32'h200) && u_sp == sp - 12, {tag, " R7 flags/sp"},
        {u_flags, u_sp}, {fl & ~32'h200, sp - 32'd12});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_done = 0; irq_req = 0; nmi_req = 0; iret_req = 0;
    vec_valid = 0; vec_data = 0; idt_base = BASE;
    cur_flags = 32'h202; cur_cs = 16'h0033; cur_pc = 32'h4000; cur_sp = 32'h1000;
    put_gate(8'h21, 32'h1234_5678, 16'h0008, 8'h8E);
    put_gate(8'h02, 32'hCAFE_0100, 16'h0018, 8'h8E);
    put_gate(8'h40, 32'h0000_1111, 16'h0020, 8'h0E);
    put_gate(8'hFF, 32'h0BAD_F00D, 16'h0028, 8'h8E);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, mem_req, upd_valid, fault, vec_ready} == 0, "R10 reset state",
        {busy, mem_req, upd_valid, fault, vec_ready}, 0);

    // R1: request without a boundary strobe
    irq_req = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!busy && !mem_req, "R1 no start without insn_done", {busy, mem_req}, 0);
    end
    irq_req = 1'b0;

    // R2: maskable request with enable clear is ignored
    cur_flags = 32'h2;
    @(negedge clk); irq_req = 1'b1; insn_done = 1'b1;
    @(negedge clk); irq_req = 1'b0; insn_done = 1'b0;
    repeat (4) begin
      chk(!busy && !vec_ready && !mem_req, "R2 masked request ignored", {busy, vec_ready, mem_req}, 0);
      @(negedge clk);
    end

    // R4/R5/R6/R7: maskable entry with a delayed vector
    cur_flags = 32'h202; cur_cs = 16'h0033; cur_pc = 32'h4000; cur_sp = 32'h1000; lat = 1;
    start(1, 0, 0, "irq21");
    repeat (2) begin
      chk(vec_ready && !mem_req, "R4 waits for vector", {vec_ready, mem_req}, 2);
      @(negedge clk);
    end
    vec_data = 8'h21; vec_valid = 1'b1;
    wait_done("irq21");
    vec_valid = 1'b0;
    chk(!vec_ready, "R4 ready low after handshake", vec_ready, 0);
    verify_entry(8'h21, 32'h202, 16'h0033, 32'h4000, 32'h1000, 32'h1234_5678, 16'h0008, "irq21");

    // R9: return pops the frame back
    cur_flags = 32'h2; cur_cs = 16'h0008; cur_pc = 32'h1234_5678; cur_sp = u_sp; lat = 0;
    start(0, 0, 1, "iret");
    wait_done("iret");
    chk(rd_a.size() == 3 && wr_a.size() == 0, "R9 three reads, no writes", {rd_a.size(), wr_a.size()}, 3 << 32);
    if (rd_a.size() == 3)
      chk(rd_a[0] == 32'hFF4 && rd_a[1] == 32'hFF8 && rd_a[2] == 32'hFFC, "R9 pop addresses",
          {rd_a[0], rd_a[2]}, {32'hFF4, 32'hFFC});
    chk(got_upd && u_pc == 32'h4000 && u_cs == 16'h0033, "R9 pc/cs restored",
        {u_pc, 16'h0, u_cs}, {32'h4000, 32'h33});
    chk(u_flags == 32'h202 && u_sp == 32'h1000, "R9 flags/sp restored", {u_flags, u_sp}, {32'h202, 32'h1000});

    // R2/R3: non-maskable with enable clear, beating a maskable request
    cur_flags = 32'h2; cur_cs = 16'h0008; cur_pc = 32'h5000; cur_sp = 32'h2000; lat = 2;
    start(1, 1, 0, "nmi");
    wait_done("nmi");
    chk(!saw_ready, "R2 R3 nmi takes no vector handshake", saw_ready, 0);
    verify_entry(8'h02, 32'h2, 16'h0008, 32'h5000, 32'h2000, 32'hCAFE_0100, 16'h0018, "nmi R3");

    // R3/R5: maskable beats return; top vector address
    cur_flags = 32'h202; cur_cs = 16'h0010; cur_pc = 32'h6000; cur_sp = 32'h3000; lat = 2;
    vec_data = 8'hFF; vec_valid = 1'b1;
    start(1, 0, 1, "irqFF");
    wait_done("irqFF");
    vec_valid = 1'b0;
    verify_entry(8'hFF, 32'h202, 16'h0010, 32'h6000, 32'h3000, 32'h0BAD_F00D, 16'h0028, "irqFF R3");

    // R8: gate not present
    cur_sp = 32'h4000; lat = 0;
    vec_data = 8'h40; vec_valid = 1'b1;
    start(1, 0, 0, "np");
    wait_done("np");
    vec_valid = 1'b0;
    chk(got_fault && !got_upd, "R8 fault without jump", {got_fault, got_upd}, 2);
    chk(wr_a.size() == 0, "R8 no pushes on fault", wr_a.size(), 0);
    chk(rd_a.size() == 2 && rd_a[0] == BASE + 32'h200, "R5 gate read for vector 0x40",
        rd_a.size() > 0 ? rd_a[0] : 0, BASE + 32'h200);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule